// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block has two register stages that share one data width. A capture stage takes a snapshot of a parallel input word when its capture strobe is high. A shift stage turns that snapshot into a serial stream. The shift stage moves one place per enabled cycle: a new bit enters at the low end, and the serial output is taken from the high end. The shift stage also has two override inputs, both active low. One copies the capture stage into the shift stage. The other forces the shift stage to zero. Both act on the output as soon as they are asserted, with no clock edge needed. Clear always wins over load.

The design uses one system clock. The two clocks of a discrete part become enable strobes: `cap_en` for the capture stage and `sh_en` for the shift stage. Each override is a level-sensitive mux in front of the serial output, so it takes effect within the same cycle. The shift register also samples the overridden value on each clock edge, so the value is kept once the override is released. A load must therefore span at least one clock edge for its value to be kept. The clear input never touches the capture stage. Only the system reset `rst_n` empties both stages.

Top module: `latched_piso`

## Requirements
- R1: While `rst_n` is low, both stages are zero and `ser_out` is 0. A load performed right after reset shifts out all zeros.
- R2: On a clock edge with `cap_en` high, the capture stage takes `par_d`. With `cap_en` low it keeps its value.
- R3: While `load_n` is low and `clear_n` is high, the shift stage shows the capture stage contents in the same cycle, with no clock edge needed. `ser_out` then equals bit W-1 of the captured word.
- R4: While `load_n` stays low, a capture edge is passed through. After that edge the shift stage shows the newly captured word.
- R5: `load_n` low overrides `sh_en`. After a load held across at least one edge is released, the shift stage holds the word that was captured at release.
- R6: On an edge with `sh_en` high and both overrides released, bit i moves to bit i+1 and `ser_in` enters bit 0. `ser_out` always shows bit W-1, so a loaded word leaves MSB first.
- R7: While `clear_n` is low, the shift stage reads zero at once and `ser_out` is 0. After release it stays zero until it is shifted or loaded.
- R8: With `clear_n` and `load_n` both low, clear wins and the shift stage reads zero.
- R9: `clear_n` leaves the capture stage untouched. A load after a clear restores the word captured before the clear.
- R10: With both overrides released and `sh_en` low, the shift stage holds its value across edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | System reset, active low, asynchronous; clears both stages |
| par_d | input | W | Parallel word to capture |
| cap_en | input | 1 | Capture strobe for the capture stage |
| sh_en | input | 1 | Shift strobe for the shift stage |
| ser_in | input | 1 | Serial bit entering bit 0 on a shift |
| load_n | input | 1 | Active-low level override: shift stage follows capture stage |
| clear_n | input | 1 | Active-low level override: shift stage reads zero (highest priority) |
| ser_out | output | 1 | Serial output, bit W-1 of the shift stage |

## Verification
Several behaviours are checked by assertions on every cycle:
- the capture and hold of the capture stage;
- the override priority, with the shift stage equal to zero under clear and equal to the capture stage under load;
- the one-place shift with the new bit at bit 0;
- holding while idle;
- retention of the loaded word after release.

Some behaviours only the bench scenarios can show. One is that an override reaches `ser_out` before any clock edge. Another is that a capture during a held load comes out in the serial stream. A third is that the capture stage survives a clear, which only shows through a later load. Each scenario reads the whole shift stage back through `ser_out` by shifting it out.

// File: rtl/lpiso_pkg.sv
package lpiso_pkg;

  // Source driving the shift stage this cycle
  typedef enum logic [1:0] {
    SRC_HELD  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_ZERO  = 2'd2
  } sh_src_e;

  // Override priority: clear over load over normal operation
  function automatic sh_src_e pick_src(input logic clear_n, input logic load_n);
    if (!clear_n)      return SRC_ZERO;
    else if (!load_n)  return SRC_STORE;
    else               return SRC_HELD;
  endfunction

endpackage

// File: rtl/lpiso_store.sv
module lpiso_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] par_d,
  output logic [W-1:0] stor_q,
  output logic [W-1:0] stor_nxt
);

  always_comb stor_nxt = cap_en ? par_d : stor_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stor_q <= '0;
    else        stor_q <= stor_nxt;
  end

endmodule

// File: rtl/lpiso_override.sv
module lpiso_override #(
  parameter int unsigned W = 8
) (
  input  lpiso_pkg::sh_src_e src,
  input  logic [W-1:0]       held,
  input  logic [W-1:0]       stor,
  output logic [W-1:0]       view
);

  always_comb begin
    unique case (src)
      lpiso_pkg::SRC_ZERO:  view = '0;
      lpiso_pkg::SRC_STORE: view = stor;
      default:              view = held;
    endcase
  end

endmodule

// File: rtl/lpiso_shift.sv
module lpiso_shift #(
  parameter int unsigned W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lpiso_pkg::sh_src_e src,
  input  logic [W-1:0]       stor_nxt,
  input  logic               sh_en,
  input  logic               ser_in,
  output logic [W-1:0]       sh_q
);

  // One place toward the MSB, new bit at bit 0
  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  logic [W-1:0] sh_nxt;

  always_comb begin
    unique case (src)
      lpiso_pkg::SRC_ZERO:  sh_nxt = '0;
      lpiso_pkg::SRC_STORE: sh_nxt = stor_nxt;
      default:              sh_nxt = sh_en ? step(sh_q, ser_in) : sh_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

endmodule

// File: rtl/latched_piso.sv
module latched_piso #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_d,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         ser_in,
  input  logic         load_n,
  input  logic         clear_n,
  output logic         ser_out
);

  lpiso_pkg::sh_src_e src;
  logic [W-1:0] stor_q, stor_nxt, sh_q, sh_view;

  // Named internal events for the checker
  logic load_act, clear_act, shift_evt;

  assign src       = lpiso_pkg::pick_src(clear_n, load_n);
  assign clear_act = (src == lpiso_pkg::SRC_ZERO);
  assign load_act  = (src == lpiso_pkg::SRC_STORE);
  assign shift_evt = (src == lpiso_pkg::SRC_HELD) && sh_en;

  lpiso_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .par_d(par_d),
    .stor_q(stor_q), .stor_nxt(stor_nxt)
  );

  lpiso_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .src(src), .stor_nxt(stor_nxt),
    .sh_en(sh_en), .ser_in(ser_in), .sh_q(sh_q)
  );

  lpiso_override #(.W(W)) u_ovr (
    .src(src), .held(sh_q), .stor(stor_q), .view(sh_view)
  );

  assign ser_out = sh_view[W-1];

endmodule

// File: rtl/lpiso_chk.sv
module lpiso_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] par_d,
  input logic         cap_en,
  input logic         ser_in,
  input logic         load_n,
  input logic         clear_n,
  input logic         shift_evt,
  input logic [W-1:0] stor_q,
  input logic [W-1:0] sh_view
);

  // R2: capture on strobe
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cap_en) |-> stor_q == $past(par_d));

  // R2: hold without strobe
  p_store_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(cap_en) |-> $stable(stor_q));

  // R3: load shows capture stage
  p_load_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && !load_n |-> sh_view == stor_q);

  // R5: word retained after load release
  p_load_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clear_n && !load_n) && clear_n && load_n |-> sh_view == stor_q);

  // R6: one-place shift
  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(shift_evt) && clear_n && load_n
      |-> sh_view == {$past(sh_view[W-2:0]), $past(ser_in)});

  // R7: clear forces zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> sh_view == '0);

  // R8: clear beats load
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n && !load_n |-> sh_view == '0);

  // R10: idle hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clear_n && load_n && !shift_evt) && clear_n && load_n
      |-> $stable(sh_view));

endmodule

bind latched_piso lpiso_chk #(.W(W)) i_lpiso_chk (
  .clk(clk), .rst_n(rst_n), .par_d(par_d), .cap_en(cap_en), .ser_in(ser_in),
  .load_n(load_n), .clear_n(clear_n), .shift_evt(shift_evt),
  .stor_q(stor_q), .sh_view(sh_view)
);

// File: tb/test_latched_piso.sv
module test_latched_piso;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par_d = '0;
  logic         cap_en = 1'b0;
  logic         sh_en = 1'b0;
  logic         ser_in = 1'b0;
  logic         load_n = 1'b1;
  logic         clear_n = 1'b1;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] st_m;   // bench model of the capture stage
  logic [W-1:0] sh_m;   // bench model of the shift stage

  always #4 clk = ~clk;

  latched_piso #(.W(W)) i_latched_piso (
    .clk(clk), .rst_n(rst_n), .par_d(par_d), .cap_en(cap_en), .sh_en(sh_en),
    .ser_in(ser_in), .load_n(load_n), .clear_n(clear_n), .ser_out(ser_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Shift the whole stage out MSB first; refills with zeros
  task automatic read_sh(input string req, input logic [W-1:0] exp);
    logic [W-1:0] got;
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = ser_out;
      sh_en = 1'b1; ser_in = 1'b0;
      tick();
    end
    sh_en = 1'b0;
    sh_m = '0;
    check(req, got, exp);
  endtask

  task automatic capture(input logic [W-1:0] v);
    par_d = v; cap_en = 1'b1;
    tick();
    cap_en = 1'b0; par_d = ~v;
    st_m = v;
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    tick();
    load_n = 1'b1;
    #1;
    sh_m = st_m;
  endtask

  task automatic t_reset();
    check("R1 ser_out in reset", {{(W-1){1'b0}}, ser_out}, '0);
    rst_n = 1'b1;
    tick();
    st_m = '0; sh_m = '0;
    pulse_load();
    read_sh("R1 storage zero after reset", '0);
  endtask

  task automatic t_capture();
    capture(8'hA5);
    tick();                       // cap_en low, par_d differs
    pulse_load();
    read_sh("R2 captured word held", 8'hA5);
  endtask

  task automatic t_load_immediate();
    capture(8'h80);
    sh_en = 1'b0;
    load_n = 1'b0;
    #1;
    check("R3 ser_out before edge", {{(W-1){1'b0}}, ser_out}, 8'h01);
    tick();
    load_n = 1'b1;
    #1;
    read_sh("R3 loaded word", 8'h80);
  endtask

  task automatic t_load_tracks();
    capture(8'h11);
    load_n = 1'b0;
    tick();
    check("R4 ser_out old MSB", {{(W-1){1'b0}}, ser_out}, 8'h00);
    par_d = 8'hE7; cap_en = 1'b1;
    tick();
    cap_en = 1'b0; st_m = 8'hE7;
    check("R4 ser_out new MSB", {{(W-1){1'b0}}, ser_out}, 8'h01);
    load_n = 1'b1;
    #1;
    read_sh("R4 word captured during load", 8'hE7);
  endtask

  task automatic t_load_override();
    capture(8'h3C);
    load_n = 1'b0; sh_en = 1'b1; ser_in = 1'b1;
    tick(); tick();
    load_n = 1'b1; sh_en = 1'b0; ser_in = 1'b0;
    #1;
    read_sh("R5 load overrides shift", 8'h3C);
  endtask

  task automatic t_shift();
    logic bits [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    capture(8'hC3);
    pulse_load();
    for (int i = 0; i < 6; i++) begin
      check("R6 serial output", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, sh_m[W-1]});
      sh_en = 1'b1; ser_in = bits[i];
      tick();
      sh_m = {sh_m[W-2:0], bits[i]};
    end
    sh_en = 1'b0; ser_in = 1'b0;
    read_sh("R6 shifted contents", {8'hC3, 6'b101101} >> 0 == 0 ? '0 : 8'hED);
  endtask

  task automatic t_clear();
    capture(8'h5A);
    pulse_load();
    clear_n = 1'b0;
    #1;
    check("R7 ser_out under clear", {{(W-1){1'b0}}, ser_out}, '0);
    tick();
    clear_n = 1'b1;
    #1;
    read_sh("R7 zero after clear", '0);
    pulse_load();
    read_sh("R9 storage survives clear", 8'h5A);
  endtask

  task automatic t_prio();
    capture(8'hFF);
    clear_n = 1'b0; load_n = 1'b0;
    #1;
    check("R8 ser_out clear wins", {{(W-1){1'b0}}, ser_out}, '0);
    tick();
    clear_n = 1'b1; load_n = 1'b1;
    #1;
    read_sh("R8 zero after joint override", '0);
  endtask

  task automatic t_hold();
    capture(8'h96);
    pulse_load();
    sh_en = 1'b0; ser_in = 1'b1;
    tick(); tick(); tick();
    ser_in = 1'b0;
    read_sh("R10 idle hold", 8'h96);
  endtask

  initial begin
    #((8 * 100000));
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_capture();
    t_load_immediate();
    t_load_tracks();
    t_load_override();
    t_shift();
    t_clear();
    t_prio();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule